// File: doc/BRIEF.md
# Serial Display Register Read Engine

This block is the read side of a four-wire serial link to a small display controller. In this link a dedicated line tells data apart from commands. A client supplies a command code, a byte count and a one-cycle start strobe. The engine pulls chip select low and drives the data/command line to its command level. It shifts the command out MSB first and then keeps clocking to collect the controller's reply. When the reply is complete it raises a done pulse with the bytes on a parallel bus. A request the engine refuses produces an error pulse instead, and the serial pins stay idle.

Two of the controller's read codes, the identifier read (0x04) and the status read (0x09), insert one idle clock before their reply. For these the engine collects one byte more than requested and slides the result left by one bit, so the client receives clean bytes. Reads use a reduced serial clock. Its frequency is the smaller of 2 MHz and half of the fastest clock the link allows. It is derived at elaboration time from the system clock frequency.

Top module: `dcs_read_engine`

## Requirements
- R1: While idle, `csN` and `dc` are high and `sclk` is low. From the cycle a transfer starts until chip select is released, `csN` and `dc` are both low, including during the reply.
- R2: The serial clock follows mode 0. `mosi` carries the command byte MSB first, changes only on a falling `sclk` edge, and is stable on every rising edge. `miso` is sampled on rising edges.
- R3: Every high and every low phase of `sclk` lasts HALF system cycles. HALF = ceil(SYS_CLK_HZ / (2·F)), where F = min(2 MHz, LINK_MAX_HZ/2). The defaults give HALF = 13.
- R4: For a normal accepted read of `len` bytes, exactly 8 + 8·len rising edges are produced. The k-th reply byte after the command (k from 0) appears on `rdData[8k+7:8k]`, and bytes at positions `len` and above read zero.
- R5: For commands 0x04 and 0x09, exactly 8 + 8·(len+1) rising edges are produced. Output byte k is formed from reply bytes r[k] and r[k+1] as (r[k] << 1) | r[k+1][7]. The result therefore holds the bits that follow the single leading idle bit.
- R6: Commands 0x04 and 0x09 are accepted only with `len` equal to 3 or 4. Any other length is refused.
- R7: A request is refused when `len` is 0, when `len` exceeds MAX_BYTES, or when the command is outside the read set {0x04, 0x06, 0x07, 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D, 0x0E, 0x0F, 0x2E, 0x3E, 0x45, 0x52, 0x54, 0x56, 0x5F, 0xA1, 0xA8}. A refusal produces a one-cycle `rdErr` in the cycle after the start strobe, with no serial activity and `csN` kept high.
- R8: `rdDone` is a one-cycle pulse, raised together with the final `rdData`, coinciding with the last falling `sclk` edge. `csN` rises HALF cycles after `rdDone` rises, counting the `rdDone` cycle as the first. `rdData` holds its value until the next accepted read completes.
- R9: A start strobe that arrives while a transfer is in progress is ignored. It produces no `rdErr`, no extra `rdDone`, and no change to the ongoing transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| cmd | input | 8 | Command code to read |
| len | input | $clog2(MAX_BYTES+1) | Requested byte count |
| rdData | output | 8·MAX_BYTES | Received bytes, byte k at bits 8k+7:8k |
| rdDone | output | 1 | Read finished, `rdData` valid |
| rdErr | output | 1 | Request refused |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the display |
| miso | input | 1 | Serial data from the display |
| csN | output | 1 | Chip select, active low |
| dc | output | 1 | Data/command select, low for command |

## Verification
The engine's request checking and its running transfer share one state machine. A new start strobe can therefore fall in the same cycle as the serial engine is busy shifting or finishing a reply. The bench provokes this by pulsing an invalid request deep inside an identifier-free read. If that request were seen it would raise an error pulse. The run is judged correct only when the scoreboard receives exactly one response, the done pulse with the expected bytes, and the clock count and chip-select timing match an undisturbed read.

// File: rtl/dcsrd_pkg.sv
package dcsrd_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // latch request, select the device
    logic sclkHi;   // raise serial clock
    logic sample;   // capture miso
    logic sclkLo;   // lower serial clock
    logic shiftTx;  // advance command shifter
    logic capture;  // store realigned reply
    logic selOff;   // release the device
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } ctrlState_t;

  function automatic logic isReadCmd(input logic [7:0] c);
    case (c)
      8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E,
      8'h0F, 8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54, 8'h56, 8'h5F, 8'hA1, 8'hA8:
        return 1'b1;
      default:
        return 1'b0;
    endcase
  endfunction

  // commands whose reply begins after one idle clock
  function automatic logic hasLeadBit(input logic [7:0] c);
    return (c == 8'h04) || (c == 8'h09);
  endfunction

endpackage

// File: rtl/dcsrd_ctrl.sv
module dcsrd_ctrl
  import dcsrd_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int LEN_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       cmdIn,
  input  logic [LEN_W-1:0] lenIn,
  input  logic             halfTick,
  output dpStrobe_t        strb,
  output logic             rdDone,
  output logic             rdErr
);

  localparam int MAX_BITS = 8 + 8 * (MAX_BYTES + 1);
  localparam int BIT_W    = $clog2(MAX_BITS + 1);

  ctrlState_t       state, stateNx;
  logic [BIT_W-1:0] bitsLeft;
  logic             reqLead, lenLegal, reqValid, lastBit;

  // request screening, evaluated only when idle
  always_comb begin
    reqLead  = hasLeadBit(cmdIn);
    lenLegal = (lenIn != '0) && (int'(lenIn) <= MAX_BYTES);
    if (reqLead)
      lenLegal = lenLegal && ((int'(lenIn) == 3) || (int'(lenIn) == 4));
    reqValid = isReadCmd(cmdIn) && lenLegal;
    lastBit  = (bitsLeft == BIT_W'(1));
  end

  always_comb begin
    strb    = '0;
    stateNx = state;
    case (state)
      ST_IDLE: begin
        if (start && reqValid) begin
          strb.load = 1'b1;
          stateNx   = ST_LOW;
        end
      end
      ST_LOW: begin
        if (halfTick) begin
          strb.sclkHi = 1'b1;
          strb.sample = 1'b1;
          stateNx     = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (halfTick) begin
          strb.sclkLo = 1'b1;
          if (lastBit) begin
            strb.capture = 1'b1;
            stateNx      = ST_TAIL;
          end else begin
            strb.shiftTx = 1'b1;
            stateNx      = ST_LOW;
          end
        end
      end
      ST_TAIL: begin
        if (halfTick) begin
          strb.selOff = 1'b1;
          stateNx     = ST_IDLE;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitsLeft <= '0;
      rdDone   <= 1'b0;
      rdErr    <= 1'b0;
    end else begin
      state  <= stateNx;
      rdDone <= strb.capture;
      rdErr  <= (state == ST_IDLE) && start && !reqValid;
      if (strb.load)
        bitsLeft <= BIT_W'(8 + 8 * (int'(lenIn) + (reqLead ? 1 : 0)));
      else if (strb.shiftTx)
        bitsLeft <= bitsLeft - BIT_W'(1);
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |=> !rdDone);

endmodule

// File: rtl/dcsrd_datapath.sv
module dcsrd_datapath
  import dcsrd_pkg::*;
#(
  parameter int HALF_CYC  = 13,
  parameter int MAX_BYTES = 4,
  parameter int LEN_W     = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strb,
  input  logic [7:0]             cmdIn,
  input  logic [LEN_W-1:0]       lenIn,
  input  logic                   miso,
  output logic                   halfTick,
  output logic                   sclk,
  output logic                   mosi,
  output logic                   csN,
  output logic                   dc,
  output logic [8*MAX_BYTES-1:0] rdData
);

  localparam int RX_BYTES = MAX_BYTES + 1;
  localparam int RX_W     = 8 * RX_BYTES;
  localparam int DIV_W    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [DIV_W-1:0]       divCnt;
  logic                   selQ, sclkQ, leadQ;
  logic [7:0]             txSh;
  logic [RX_W-1:0]        rxSh, aligned;
  logic [LEN_W-1:0]       lenQ;
  logic [LEN_W:0]         nRx;
  logic [8*MAX_BYTES-1:0] outBytes;

  // half-period timer runs only while the device is selected
  assign halfTick = selQ && (divCnt == DIV_W'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (strb.load || !selQ) begin
      divCnt <= '0;
    end else if (halfTick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= 1'b0;
      sclkQ <= 1'b0;
      txSh  <= '0;
      rxSh  <= '0;
      lenQ  <= '0;
      leadQ <= 1'b0;
    end else begin
      if (strb.load) begin
        selQ  <= 1'b1;
        txSh  <= cmdIn;
        rxSh  <= '0;
        lenQ  <= lenIn;
        leadQ <= hasLeadBit(cmdIn);
      end else if (strb.selOff) begin
        selQ <= 1'b0;
      end
      if (strb.sclkHi) sclkQ <= 1'b1;
      else if (strb.sclkLo) sclkQ <= 1'b0;
      if (strb.shiftTx) txSh <= {txSh[6:0], 1'b0};
      if (strb.sample) rxSh <= {rxSh[RX_W-2:0], miso};
    end
  end

  // move the first reply bit to the top, then drop the idle bit if present
  assign nRx = {1'b0, lenQ} + (LEN_W + 1)'(leadQ);

  always_comb begin
    aligned = rxSh << ((RX_BYTES - int'(nRx)) * 8);
    if (leadQ) aligned = aligned << 1;
  end

  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_byte
    assign outBytes[8*i +: 8] = (i < int'(lenQ)) ? aligned[RX_W-1-8*i -: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strb.capture) rdData <= outBytes;
  end

  assign sclk = sclkQ;
  assign mosi = txSh[7];
  assign csN  = ~selQ;
  assign dc   = ~selQ;

  // R3
  sclk_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclkQ != $past(sclkQ)) |-> $past(halfTick));

  // R2
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclkQ && $past(sclkQ)) |-> $stable(txSh[7]));

  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !selQ |-> !sclkQ);

endmodule

// File: rtl/dcs_read_engine.sv
module dcs_read_engine
  import dcsrd_pkg::*;
#(
  parameter int SYS_CLK_HZ  = 50_000_000,
  parameter int LINK_MAX_HZ = 20_000_000,
  parameter int MAX_BYTES   = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           start,
  input  logic [7:0]                     cmd,
  input  logic [$clog2(MAX_BYTES+1)-1:0] len,
  output logic [8*MAX_BYTES-1:0]         rdData,
  output logic                           rdDone,
  output logic                           rdErr,
  output logic                           sclk,
  output logic                           mosi,
  input  logic                           miso,
  output logic                           csN,
  output logic                           dc
);

  localparam int LEN_W    = $clog2(MAX_BYTES + 1);
  localparam int RD_HZ    = (LINK_MAX_HZ / 2 < 2_000_000) ? LINK_MAX_HZ / 2 : 2_000_000;
  localparam int HALF_RAW = (SYS_CLK_HZ + 2 * RD_HZ - 1) / (2 * RD_HZ);
  localparam int HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;

  dpStrobe_t strb;
  logic      halfTick;

  dcsrd_ctrl #(
    .MAX_BYTES(MAX_BYTES),
    .LEN_W    (LEN_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .cmdIn   (cmd),
    .lenIn   (len),
    .halfTick(halfTick),
    .strb    (strb),
    .rdDone  (rdDone),
    .rdErr   (rdErr)
  );

  dcsrd_datapath #(
    .HALF_CYC (HALF_CYC),
    .MAX_BYTES(MAX_BYTES),
    .LEN_W    (LEN_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cmdIn   (cmd),
    .lenIn   (len),
    .miso    (miso),
    .halfTick(halfTick),
    .sclk    (sclk),
    .mosi    (mosi),
    .csN     (csN),
    .dc      (dc),
    .rdData  (rdData)
  );

  // R8
  done_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |-> (!csN && !sclk));

  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> csN);

endmodule

// File: tb/dcs_read_engine_test.sv
module dcs_read_engine_test;

  localparam int SYS_HZ  = 50_000_000;
  localparam int LINK_HZ = 20_000_000;
  localparam int MAXB    = 4;
  localparam int F_RD    = (LINK_HZ / 2 < 2_000_000) ? LINK_HZ / 2 : 2_000_000;
  localparam int HALF    = (SYS_HZ + 2 * F_RD - 1) / (2 * F_RD);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cmd = 8'h00;
  logic [2:0]  len = 3'd0;
  logic [31:0] rdData;
  logic        rdDone, rdErr, sclk, mosi, csN, dc;
  logic        miso = 1'b0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  dcs_read_engine #(
    .SYS_CLK_HZ (SYS_HZ),
    .LINK_MAX_HZ(LINK_HZ),
    .MAX_BYTES  (MAXB)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .len(len),
    .rdData(rdData), .rdDone(rdDone), .rdErr(rdErr),
    .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN), .dc(dc)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // display model: bit stream popped on falling clock edges
  bit sq[$];
  always @(negedge sclk or negedge csN) begin
    if (!csN) miso <= (sq.size() != 0) ? sq.pop_front() : 1'b1;
  end

  // bus observers
  int         riseCnt = 0;
  int         dcBad = 0;
  logic [7:0] cmdCap = 8'h00;
  bit         csFell = 0;
  bit         endSeen = 0;
  always @(posedge sclk) begin
    if (!csN) begin
      if (riseCnt < 8) cmdCap = {cmdCap[6:0], mosi};
      if (dc !== 1'b0) dcBad++;
      riseCnt++;
    end
  end
  always @(negedge csN) csFell = 1;
  always @(posedge csN) endSeen = 1;

  int hiRun = 0, hiBad = 0, hiSeen = 0;
  int gapCnt = 0, gapLast = 0;
  bit gapOn = 0;
  always @(negedge clk) begin
    if (sclk) hiRun++;
    else if (hiRun != 0) begin
      hiSeen++;
      if (hiRun != HALF) hiBad++;
      hiRun = 0;
    end
    if (rdDone) begin
      gapOn = 1; gapCnt = 1;
    end else if (gapOn) begin
      if (!csN) gapCnt++;
      else begin gapOn = 0; gapLast = gapCnt; end
    end
  end

  // scoreboard
  bit          expErrQ[$];
  logic [31:0] expDataQ[$];
  string       expTagQ[$];
  int          respCnt = 0;

  always @(negedge clk) begin
    if (rstN && (rdDone || rdErr)) begin
      respCnt++;
      if (expErrQ.size() == 0) begin
        check(0, "R9", "unexpected response", {30'b0, rdErr, rdDone}, 32'h0);
      end else begin
        bit          e;
        logic [31:0] d;
        string       t;
        e = expErrQ.pop_front();
        d = expDataQ.pop_front();
        t = expTagQ.pop_front();
        check(rdErr == e && rdDone == !e, t, "response kind", {31'b0, rdErr}, {31'b0, e});
        if (!e) check(rdData == d, t, "read bytes", rdData, d);
      end
    end
  end

  task automatic runRead(input logic [7:0] c, input int n, input logic [31:0] bytes,
                         input bit leadBit, input bit expErr, input bit inject,
                         input string tag);
    bit          lead;
    logic [31:0] expD;
    int          r0, w, nRx;
    lead = (c == 8'h04) || (c == 8'h09);
    sq.delete();
    for (int i = 0; i < 8; i++) sq.push_back(1'b1);
    if (lead) sq.push_back(leadBit);
    for (int k = 0; k < n && k < 4; k++)
      for (int b = 7; b >= 0; b--) sq.push_back(bytes[8*k+b]);
    for (int i = 0; i < 16; i++) sq.push_back(1'b1);
    expD = 32'h0;
    for (int k = 0; k < n && k < 4; k++) expD[8*k +: 8] = bytes[8*k +: 8];
    expErrQ.push_back(expErr);
    expDataQ.push_back(expD);
    expTagQ.push_back(tag);
    riseCnt = 0; dcBad = 0; cmdCap = 8'h00; csFell = 0; endSeen = 0;
    hiBad = 0; hiSeen = 0; gapLast = 0;
    r0 = respCnt;
    @(negedge clk);
    start = 1'b1; cmd = c; len = 3'(n);
    @(negedge clk);
    start = 1'b0;
    if (expErr) begin
      repeat (4) @(negedge clk);
      check(!csFell, "R7", "chip select stayed high", {31'b0, csFell}, 32'h0);
      check(riseCnt == 0, "R7", "no clocks on refusal", riseCnt, 0);
    end else begin
      if (inject) begin
        repeat (150) @(negedge clk);
        start = 1'b1; cmd = 8'h00; len = 3'd0;
        @(negedge clk);
        start = 1'b0;
      end
      w = 0;
      while (!endSeen && w < 5000) begin @(negedge clk); w++; end
      repeat (3) @(negedge clk);
      nRx = n + (lead ? 1 : 0);
      check(riseCnt == 8 + 8 * nRx, lead ? "R5" : "R4", "clock count", riseCnt, 8 + 8 * nRx);
      check(cmdCap == c, "R2", "command on mosi", cmdCap, c);
      check(dcBad == 0, "R1", "dc low during transfer", dcBad, 0);
      check(hiBad == 0 && hiSeen > 0, "R3", "sclk high phase", hiBad, 0);
      check(gapLast == HALF, "R8", "done to release gap", gapLast, HALF);
      check(csN && dc && !sclk, "R1", "idle levels after transfer", {29'b0, csN, dc, sclk}, 32'h6);
    end
    check(respCnt - r0 == 1, inject ? "R9" : tag, "one response", respCnt - r0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R8", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(csN && dc && !sclk, "R1", "reset pin levels", {29'b0, csN, dc, sclk}, 32'h6);
    check(!rdDone && !rdErr && rdData == 0, "R8", "reset outputs",
          {rdData[29:0], rdDone, rdErr}, 32'h0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    runRead(8'h0A, 1, 32'h000000A5, 1'b0, 1'b0, 1'b0, "R4");
    runRead(8'h2E, 2, 32'h00003412, 1'b0, 1'b0, 1'b0, "R4");
    runRead(8'h0C, 4, 32'h7B1E66C3, 1'b0, 1'b0, 1'b0, "R4");
    runRead(8'h04, 3, 32'h00F13C85, 1'b1, 1'b0, 1'b0, "R5");
    runRead(8'h09, 4, 32'hEFBEADDE, 1'b0, 1'b0, 1'b0, "R5");
    runRead(8'h04, 4, 32'h01800F7E, 1'b0, 1'b0, 1'b0, "R5");
    runRead(8'h0A, 0, 32'h0, 1'b0, 1'b1, 1'b0, "R7");
    runRead(8'h0A, 5, 32'h0, 1'b0, 1'b1, 1'b0, "R7");
    runRead(8'h2C, 1, 32'h0, 1'b0, 1'b1, 1'b0, "R7");
    runRead(8'h04, 2, 32'h0, 1'b0, 1'b1, 1'b0, "R6");
    runRead(8'h09, 1, 32'h0, 1'b0, 1'b1, 1'b0, "R6");
    runRead(8'h0B, 2, 32'h00005AC3, 1'b0, 1'b0, 1'b1, "R9");
    // R8: data held after completion until the next accepted read
    repeat (20) @(negedge clk);
    check(rdData == 32'h00005AC3, "R8", "data held", rdData, 32'h00005AC3);
    runRead(8'hA8, 1, 32'h0000003C, 1'b0, 1'b0, 1'b0, "R4");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule